// File: doc/BRIEF.md
# Flash-to-Memory DMA Address Engine

This block is the address and sequencing core of a DMA engine that sits beside a serial flash controller. Software programs a flash-side word address, a memory-side start address that is 40 bits wide, a byte length and a direction, then sets a start bit. The engine then moves 32-bit words one at a time. Each word is read from the source side and then written to the destination side, over two simple request/acknowledge ports, one for flash and one for memory.

Software supplies the memory address as a system address: a 32-bit low word plus an 8-bit high byte. The engine subtracts the fixed base at which memory appears in the system map, so the memory port carries a local offset. Both programmed addresses are working counters. Software can read them at any time to see the live position of the transfer. After completion they hold the address one word past the last word moved.

Top module: `fdma_addr_engine`

## Requirements
- R1: After reset, every register reads 0: ctrl at 0x80, flash address at 0x84, memory low word at 0x88, memory high byte at 0x7C and length at 0x8C.
- R2: In the high register at 0x7C, bits 7:0 are read/write. Bits 31:8 always read 0, whatever was written.
- R3: The memory port address is {high byte, low word} minus 0x4_0000_0000. A high byte of 4 with a low word of 0x10 gives port address 0x10.
- R4: At start, bits 1:0 of the memory address and of the flash address are cleared. Each completed word advances both addresses by 4.
- R5: Reading 0x88 and 0x7C returns the live working address, both during a transfer and after it. After a full transfer of N words the value is the aligned start plus 4·N.
- R6: Ctrl bit 30 selects the direction. With 0, each flash word read is written to memory. With 1, each memory word read is written to flash. The two ports never request in the same cycle.
- R7: Writing ctrl with bit 31 set while idle starts a transfer. Bit 31 reads 1 while the engine is busy. Ctrl bit 0 (done) is cleared at start and set on normal completion.
- R8: The length at 0x8C counts bytes in its low 25 bits, and the upper bits are dropped. The word count is ceil(length/4). A length of 0 completes with no port requests.
- R9: A carry out of bit 31 of the memory low word increments the high byte.
- R10: While busy, writes to 0x7C, 0x84, 0x88 and 0x8C are ignored.
- R11: Writing ctrl with bit 31 clear while busy stops the transfer after the word in flight. Done stays 0, and the addresses reflect only the words that were moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset, used for both read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| fl_req | output | 1 | Flash-side request |
| fl_we | output | 1 | Flash-side write (1) or read (0) |
| fl_addr | output | 32 | Flash word address |
| fl_wdata | output | 32 | Flash write data |
| fl_rdata | input | 32 | Flash read data, valid with fl_ack |
| fl_ack | input | 1 | Flash-side acknowledge |
| mem_req | output | 1 | Memory-side request |
| mem_we | output | 1 | Memory-side write (1) or read (0) |
| mem_addr | output | 40 | Local memory address (base removed) |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory-side acknowledge |

## Verification
A register write lands at the next rising edge. The start write moves the engine into a check state. The source request appears one cycle later, and with a same-cycle acknowledge each word takes three cycles: check, source and destination. Because address steps land on the edge of the destination acknowledge, the bench reads the live address only at falling edges after it has seen that write on the memory port. For complete transfers the bench polls the busy bit at falling edges and checks done, the final addresses and the moved data only once busy has cleared. The abort case is checked against the word count the bench observed on the port, not against a guessed cycle.

// File: rtl/fdma_pkg.sv
package fdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CHK  = 2'd1,
    ST_SRC  = 2'd2,
    ST_DST  = 2'd3
  } fdma_state_t;

  localparam logic [7:0] OFS_MHI  = 8'h7C;
  localparam logic [7:0] OFS_CTRL = 8'h80;
  localparam logic [7:0] OFS_FLA  = 8'h84;
  localparam logic [7:0] OFS_MLO  = 8'h88;
  localparam logic [7:0] OFS_LEN  = 8'h8C;

  localparam int CTRL_GO   = 31;
  localparam int CTRL_DIR  = 30;
  localparam int CTRL_DONE = 0;
endpackage

// File: rtl/fdma_regs.sv
module fdma_regs
  import fdma_pkg::*;
#(
  parameter int HI_W  = 8,
  parameter int LEN_W = 25,
  localparam int MEM_W = 32 + HI_W,
  localparam int CNT_W = LEN_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [7:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             step,
  input  logic             finish,
  output logic             start,
  output logic             abort,
  output logic             dir,
  output logic             words_zero,
  output logic [MEM_W-1:0] work_addr,
  output logic [31:0]      fla_addr
);
  logic [MEM_W-1:0] work_q, work_d;
  logic [31:0]      fla_q, fla_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             dir_q, dir_d;
  logic             done_q, done_d;
  logic             wr_ok, ctrl_wr;
  logic [LEN_W:0]   len_rnd;

  assign wr_ok   = reg_we && !busy;
  assign ctrl_wr = reg_we && (reg_addr == OFS_CTRL);
  assign start   = ctrl_wr && reg_wdata[CTRL_GO] && !busy;
  assign abort   = ctrl_wr && !reg_wdata[CTRL_GO] && busy;
  assign len_rnd = {1'b0, len_q} + (LEN_W+1)'(3);

  always_comb begin
    work_d = work_q;
    fla_d  = fla_q;
    len_d  = len_q;
    rem_d  = rem_q;
    dir_d  = dir_q;
    done_d = done_q;
    if (wr_ok) begin
      case (reg_addr)
        OFS_MHI:  work_d[MEM_W-1:32] = reg_wdata[HI_W-1:0];
        OFS_MLO:  work_d[31:0]       = reg_wdata;
        OFS_FLA:  fla_d              = reg_wdata;
        OFS_LEN:  len_d              = reg_wdata[LEN_W-1:0];
        OFS_CTRL: dir_d              = reg_wdata[CTRL_DIR];
        default: ;
      endcase
    end
    if (start) begin
      work_d[1:0] = 2'b00;
      fla_d[1:0]  = 2'b00;
      rem_d       = len_rnd[LEN_W:2];
      done_d      = 1'b0;
    end
    if (step) begin
      work_d = work_q + MEM_W'(4);
      fla_d  = fla_q + 32'd4;
      rem_d  = rem_q - CNT_W'(1);
    end
    if (finish) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      work_q <= '0;
      fla_q  <= '0;
      len_q  <= '0;
      rem_q  <= '0;
      dir_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      work_q <= work_d;
      fla_q  <= fla_d;
      len_q  <= len_d;
      rem_q  <= rem_d;
      dir_q  <= dir_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_MHI:  reg_rdata = 32'(work_q[MEM_W-1:32]);
      OFS_MLO:  reg_rdata = work_q[31:0];
      OFS_FLA:  reg_rdata = fla_q;
      OFS_LEN:  reg_rdata = 32'(len_q);
      OFS_CTRL: reg_rdata = {busy, dir_q, 29'd0, done_q};
      default:  reg_rdata = 32'd0;
    endcase
  end

  assign dir        = dir_q;
  assign words_zero = (rem_q == '0);
  assign work_addr  = work_q;
  assign fla_addr   = fla_q;

  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (work_q[1:0] == 2'b00 && fla_q[1:0] == 2'b00)); // R4
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> $stable(work_q) && $stable(fla_q) && $stable(len_q)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R7
endmodule

// File: rtl/fdma_seq.sv
module fdma_seq
  import fdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              dir,
  input  logic              words_zero,
  input  logic              fl_ack,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              step,
  output logic              finish,
  output logic              fl_req,
  output logic              fl_we,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] wdata
);
  fdma_state_t st_q, st_d;
  logic              stop_q, stop_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              src_ack, dst_ack, leave;

  assign src_ack = dir ? mem_ack : fl_ack;
  assign dst_ack = dir ? fl_ack : mem_ack;
  assign leave   = words_zero || stop_q || abort;

  always_comb begin
    st_d   = st_q;
    stop_d = stop_q;
    buf_d  = buf_q;
    if (abort) stop_d = 1'b1;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_CHK;
        stop_d = 1'b0;
      end
      ST_CHK: st_d = leave ? ST_IDLE : ST_SRC;
      ST_SRC: if (src_ack) begin
        st_d  = ST_DST;
        buf_d = dir ? mem_rdata : fl_rdata;
      end
      ST_DST: if (dst_ack) st_d = ST_CHK;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      stop_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      st_q   <= st_d;
      stop_q <= stop_d;
      buf_q  <= buf_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign step    = (st_q == ST_DST) && dst_ack;
  assign finish  = (st_q == ST_CHK) && words_zero && !stop_q && !abort;
  assign fl_req  = (st_q == ST_SRC && !dir) || (st_q == ST_DST && dir);
  assign fl_we   = (st_q == ST_DST);
  assign mem_req = (st_q == ST_SRC && dir) || (st_q == ST_DST && !dir);
  assign mem_we  = (st_q == ST_DST);
  assign wdata   = buf_q;

  AST_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_req && mem_req)); // R6
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && st_q == ST_CHK) |=> !busy); // R11
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req); // R6
endmodule

// File: rtl/fdma_addr_engine.sv
module fdma_addr_engine
  import fdma_pkg::*;
#(
  parameter int HI_W  = 8,
  parameter int LEN_W = 25,
  parameter logic [32+HI_W-1:0] MEM_BASE = (32+HI_W)'(40'h04_0000_0000)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               fl_req,
  output logic               fl_we,
  output logic [31:0]        fl_addr,
  output logic [31:0]        fl_wdata,
  input  logic [31:0]        fl_rdata,
  input  logic               fl_ack,
  output logic               mem_req,
  output logic               mem_we,
  output logic [32+HI_W-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_ack
);
  localparam int MEM_W = 32 + HI_W;

  logic             busy, step, finish, start, abort, dir, words_zero;
  logic [MEM_W-1:0] work_addr;
  logic [31:0]      wdata;

  fdma_regs #(.HI_W(HI_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .step(step),
    .finish(finish), .start(start), .abort(abort), .dir(dir),
    .words_zero(words_zero), .work_addr(work_addr), .fla_addr(fl_addr)
  );

  fdma_seq #(.DATA_W(32)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .dir(dir),
    .words_zero(words_zero), .fl_ack(fl_ack), .fl_rdata(fl_rdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .step(step),
    .finish(finish), .fl_req(fl_req), .fl_we(fl_we), .mem_req(mem_req),
    .mem_we(mem_we), .wdata(wdata)
  );

  assign mem_addr  = work_addr - MEM_BASE;
  assign fl_wdata  = wdata;
  assign mem_wdata = wdata;

  AST_LOCAL_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
endmodule

// File: tb/fdma_addr_engine_tb.sv
module fdma_addr_engine_tb;
  localparam time TCK = 20ns;
  localparam logic [39:0] BASE = 40'h04_0000_0000;

  typedef struct packed {
    logic        dir;
    logic [7:0]  hi;
    logic [31:0] lo;
    logic [31:0] fl;
    logic [31:0] len;
    logic [7:0]  nw;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{1'b0, 8'h04, 32'h0000_0010, 32'h0000_0020, 32'h0000_000C, 8'd3},
    '{1'b1, 8'h04, 32'h0000_0043, 32'h0000_0081, 32'hFE00_0009, 8'd3},
    '{1'b0, 8'h04, 32'hFFFF_FFF8, 32'h0000_00C0, 32'h0000_0010, 8'd4},
    '{1'b0, 8'h04, 32'h0000_0100, 32'h0000_0000, 32'h0000_0000, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [7:0] reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0, reg_rdata;
  logic fl_req, fl_we, fl_ack, mem_req, mem_we, mem_ack;
  logic [31:0] fl_addr, fl_wdata, fl_rdata, mem_wdata, mem_rdata;
  logic [39:0] mem_addr, first_maddr;
  logic [31:0] flash_m [64];
  logic [31:0] mem_m [64];
  int errs = 0, checks = 0, reqs = 0, mwrites = 0, both = 0;
  bit got_first = 0;

  always #(TCK/2) clk = ~clk;

  fdma_addr_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_req(fl_req),
    .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_ack(fl_ack), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  assign fl_ack    = fl_req;
  assign mem_ack   = mem_req;
  assign fl_rdata  = flash_m[fl_addr[7:2]];
  assign mem_rdata = mem_m[mem_addr[7:2]];

  function automatic logic [31:0] finit(int i);
    return 32'hF000_0000 | (32'(i) * 32'h0101);
  endfunction
  function automatic logic [31:0] minit(int i);
    return 32'hA500_0000 | 32'(i);
  endfunction

  always @(posedge clk) begin
    if (fl_req || mem_req) reqs <= reqs + 1;
    if (fl_req && mem_req) both <= both + 1;
    if (fl_req && fl_we) flash_m[fl_addr[7:2]] <= fl_wdata;
    if (mem_req && mem_we) begin
      mem_m[mem_addr[7:2]] <= mem_wdata;
      mwrites <= mwrites + 1;
    end
    if (mem_req && !got_first) begin
      got_first   <= 1'b1;
      first_maddr <= mem_addr;
    end
  end

  task automatic chk(string r, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int t = 0; t < 2000; t++) begin
      @(negedge clk);
      rd(8'h80, c);
      if (!c[31]) return;
    end
    chk("R7 idle timeout", 40'd1, 40'd0);
  endtask

  initial begin
    #(TCK * 150000);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [39:0] s40, e40;
    logic [31:0] fa0;
    for (int i = 0; i < 64; i++) begin
      flash_m[i] = finit(i);
      mem_m[i]   = minit(i);
    end
    #(TCK * 3);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset values
    foreach (VEC[i]) begin end
    rd(8'h80, d); chk("R1 ctrl", 40'(d), 40'd0);
    rd(8'h84, d); chk("R1 flash addr", 40'(d), 40'd0);
    rd(8'h88, d); chk("R1 mem low", 40'(d), 40'd0);
    rd(8'h7C, d); chk("R1 mem high", 40'(d), 40'd0);
    rd(8'h8C, d); chk("R1 length", 40'(d), 40'd0);
    // R2: reserved bits of high register
    wr(8'h7C, 32'hFFFF_FFAB);
    rd(8'h7C, d); chk("R2 high reserved", 40'(d), 40'h0000_00AB);

    // vector table walk: R3 R4 R5 R6 R7 R8 R9
    for (int v = 0; v < 4; v++) begin
      wr(8'h7C, 32'(VEC[v].hi));
      wr(8'h88, VEC[v].lo);
      wr(8'h84, VEC[v].fl);
      wr(8'h8C, VEC[v].len);
      s40 = {VEC[v].hi, VEC[v].lo & 32'hFFFF_FFFC};
      fa0 = VEC[v].fl & 32'hFFFF_FFFC;
      got_first = 1'b0; reqs = 0;
      wr(8'h80, {1'b1, VEC[v].dir, 30'd0});
      rd(8'h80, d); chk("R7 busy/done-clear at start", 40'({d[31], d[0]}), 40'b10);
      wait_idle();
      rd(8'h80, d); chk("R7 done after completion", 40'(d[0]), 40'd1);
      e40 = s40 + 40'(4 * VEC[v].nw);
      rd(8'h88, d); chk("R5 R9 final low word", 40'(d), 40'(e40[31:0]));
      rd(8'h7C, d); chk("R5 R9 final high byte", 40'(d), 40'(e40[39:32]));
      rd(8'h84, d); chk("R4 final flash addr", 40'(d), 40'(fa0 + 32'(4 * VEC[v].nw)));
      if (VEC[v].nw == 0) chk("R8 zero length no requests", 40'(reqs), 40'd0);
      else begin
        chk("R3 local memory address", first_maddr, s40 - BASE);
        chk("R8 request cycles", 40'(reqs), 40'(2 * VEC[v].nw));
      end
      for (int k = 0; k < VEC[v].nw; k++) begin
        logic [39:0] la;
        logic [31:0] fa;
        la = s40 + 40'(4 * k) - BASE;
        fa = fa0 + 32'(4 * k);
        if (!VEC[v].dir) chk("R6 flash-to-memory data", 40'(mem_m[la[7:2]]), 40'(finit(int'(fa[7:2]))));
        else chk("R6 memory-to-flash data", 40'(flash_m[fa[7:2]]), 40'(minit(int'(la[7:2]))));
      end
    end
    chk("R6 no simultaneous requests", 40'(both), 40'd0);

    // R5 R10 R11: live address, ignored writes, abort
    wr(8'h7C, 32'h4);
    wr(8'h88, 32'h0);
    wr(8'h84, 32'h0);
    wr(8'h8C, 32'd40);
    mwrites = 0;
    wr(8'h80, 32'h8000_0000);
    while (mwrites < 2) @(negedge clk);
    rd(8'h88, d); chk("R5 live low word", 40'(d), 40'(4 * mwrites));
    rd(8'h80, d); chk("R7 busy bit", 40'(d[31]), 40'd1);
    wr(8'h88, 32'h0000_0500);
    wr(8'h7C, 32'h0000_0009);
    wr(8'h8C, 32'd4);
    wr(8'h80, 32'h0000_0000);
    wait_idle();
    rd(8'h80, d); chk("R11 done stays clear", 40'(d[0]), 40'd0);
    chk("R11 stopped early", 40'(mwrites < 10), 40'd1);
    rd(8'h88, d); chk("R10 R11 low word tracks moved words", 40'(d), 40'(4 * mwrites));
    rd(8'h7C, d); chk("R10 high write ignored", 40'(d), 40'd4);
    rd(8'h8C, d); chk("R10 length write ignored", 40'(d), 40'd40);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule